// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves 8-bit data between two ports, A and B, in either direction. Each direction owns a storage register, a capture strobe and a source select. The select decides whether the far port sees live data or the value that was captured earlier. Tri-state pads are modelled as a separate input vector, output vector and output-enable flag for each port. The enable for the B side is active high and the enable for the A side is active low.

Everything runs on one system clock. The two capture strobes arrive asynchronously. Each one passes through a synchroniser and then an edge-detection state machine, which produces a single-cycle capture pulse. The machine has three states:

- EDGE_IDLE: the strobe is low.
- EDGE_FIRE: the first cycle in which the synchronised strobe is high. This is the only state that raises the pulse.
- EDGE_WAIT: the strobe is still high.

The transitions are:

- IDLE to FIRE on a high level.
- FIRE to WAIT on a high level.
- WAIT to WAIT on a high level.
- Any state to IDLE on a low level.

Each port resolves to a single "seen" value. When the port's own output is enabled, the seen value is what the port drives; otherwise it is the port's external input. The live path carries a registered copy of the far port's seen value. This lets two enabled live directions hold the bus without forming a combinational loop.

Top module: `xcvr_top`

## Requirements
- R1: Data passes with its bits unchanged. Bit i of the source appears as bit i of the destination for all 256 values of the 8-bit width.
- R2: `b_oe` equals `b_drive_en` (active high). `a_oe` equals the inverse of `a_drive_en_n` (active low). Both follow without delay.
- R3: A select of 0 (live) makes the far port's output equal the seen value of the source port one clock earlier.
- R4: A select of 1 (held) makes the far port's output equal that direction's storage register. It stays constant while no capture pulse occurs.
- R5: Each rising edge of a capture strobe loads the source port's seen value into its register exactly once, whatever the selects and enables. The load takes effect 3 clocks after the first edge that samples the strobe high. Holding the strobe high causes no further loads.
- R6: A capture on a port whose output is enabled stores the value that port drives; its external input is ignored.
- R7: With B enabled and A-to-B live, a capture on A followed by a capture on B leaves the A value in both registers.
- R8: With both ports enabled and both selects live, the two outputs keep their common value while both external inputs change.
- R9: With both ports enabled and both selects held, B shows the A register and A shows the B register at the same time.
- R10: With both selects held and both ports enabled, coincident strobes exchange the two register contents. A single strobe copies the other register.
- R11: Synchronous active-high reset clears both registers, both live copies and the capture logic. After reset, held outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Value arriving at port A from outside |
| a_out | output | 8 | Value port A drives |
| a_oe | output | 1 | Port A pad enable |
| b_in | input | 8 | Value arriving at port B from outside |
| b_out | output | 8 | Value port B drives |
| b_oe | output | 1 | Port B pad enable |
| a_drive_en_n | input | 1 | Enable for driving port A, active low |
| b_drive_en | input | 1 | Enable for driving port B, active high |
| a_to_b_held | input | 1 | 1: B gets the A register; 0: B gets live A |
| b_to_a_held | input | 1 | 1: A gets the B register; 0: A gets live B |
| cap_a_strobe | input | 1 | Rising edge captures port A into the A register |
| cap_b_strobe | input | 1 | Rising edge captures port B into the B register |

## Verification
The following properties are checked by assertions on every cycle:

- The live path lags the source's seen value by exactly one clock.
- A held output stays constant when no capture pulse occurs.
- A capture pulse lasts a single cycle and lands the seen value in the register.
- A bus loop formed by two enabled live directions holds its value.

Some behaviour is shown only by the bench's scenarios:

- The latency from strobe to load, and the absence of a second load while the strobe stays high.
- The two-step load of both registers from one port.
- The register exchange on coincident strobes.
- The sweep of all 256 data values through the capture and live paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Capture-strobe edge detector states
    typedef enum logic [1:0] {
        EDGE_IDLE = 2'd0,
        EDGE_FIRE = 2'd1,
        EDGE_WAIT = 2'd2
    } edge_state_e;

    // Source choice for one direction of transfer
    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } lane_src_e;

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/xcvr_edge_fsm.sv
module xcvr_edge_fsm
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fire
);
    edge_state_e state_q;
    edge_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= EDGE_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = EDGE_IDLE;
        unique case (state_q)
            EDGE_IDLE: state_d = level ? EDGE_FIRE : EDGE_IDLE;
            EDGE_FIRE: state_d = level ? EDGE_WAIT : EDGE_IDLE;
            EDGE_WAIT: state_d = level ? EDGE_WAIT : EDGE_IDLE;
            default:   state_d = EDGE_IDLE;
        endcase
    end

    // Output logic: one pulse per entry into FIRE
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            EDGE_FIRE: fire = 1'b1;
            EDGE_IDLE,
            EDGE_WAIT: fire = 1'b0;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en,
    input  logic         held_sel,
    input  logic [W-1:0] src_seen,
    output logic [W-1:0] dst_data
);
    logic [W-1:0] store_q;
    logic [W-1:0] live_q;
    lane_src_e    src;

    // Storage register: loads only on a capture pulse
    always_ff @(posedge clk) begin
        if (rst)         store_q <= '0;
        else if (cap_en) store_q <= src_seen;
    end

    // Registered copy of the source port; keeps the bus loop sequential
    always_ff @(posedge clk) begin
        if (rst) live_q <= '0;
        else     live_q <= src_seen;
    end

    assign src = lane_src_e'(held_sel);

    always_comb begin
        dst_data = live_q;
        unique case (src)
            SRC_LIVE: dst_data = live_q;
            SRC_HELD: dst_data = store_q;
            default:  dst_data = live_q;
        endcase
    end
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         a_drive_en_n,
    input  logic         b_drive_en,
    input  logic         a_to_b_held,
    input  logic         b_to_a_held,
    input  logic         cap_a_strobe,
    input  logic         cap_b_strobe
);
    localparam int NDIR = 2;

    logic [NDIR-1:0] strobe_raw;
    logic [NDIR-1:0] strobe_sync;
    logic [NDIR-1:0] cap_fire;
    logic            cap_a_fire;
    logic            cap_b_fire;
    logic [W-1:0]    a_seen;
    logic [W-1:0]    b_seen;

    // Pad enables with opposite polarities
    assign a_oe = ~a_drive_en_n;
    assign b_oe = b_drive_en;

    // Bus resolution: an enabled port sees its own drive
    assign a_seen = a_oe ? a_out : a_in;
    assign b_seen = b_oe ? b_out : b_in;

    assign strobe_raw = {cap_b_strobe, cap_a_strobe};

    generate
        for (genvar i = 0; i < NDIR; i++) begin : g_strobe
            xcvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (strobe_raw[i]),
                .q   (strobe_sync[i])
            );
            xcvr_edge_fsm u_edge (
                .clk   (clk),
                .rst   (rst),
                .level (strobe_sync[i]),
                .fire  (cap_fire[i])
            );
        end
    endgenerate

    assign cap_a_fire = cap_fire[0];
    assign cap_b_fire = cap_fire[1];

    // A register, feeds port B
    xcvr_lane #(.W(W)) u_lane_ab (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_a_fire),
        .held_sel (a_to_b_held),
        .src_seen (a_seen),
        .dst_data (b_out)
    );

    // B register, feeds port A
    xcvr_lane #(.W(W)) u_lane_ba (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_b_fire),
        .held_sel (b_to_a_held),
        .src_seen (b_seen),
        .dst_data (a_out)
    );
endmodule

// File: rtl/xcvr_checks.sv
module xcvr_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         a_to_b_held,
    input logic         b_to_a_held,
    input logic         cap_a_fire,
    input logic         cap_b_fire
);
    logic [W-1:0] a_res;
    logic [W-1:0] b_res;
    logic         loop_live;

    assign a_res     = a_oe ? a_out : a_in;
    assign b_res     = b_oe ? b_out : b_in;
    assign loop_live = a_oe && b_oe && !a_to_b_held && !b_to_a_held;

    assert_live_ab_R3: assert property (@(posedge clk) disable iff (rst)
        (!a_to_b_held && $past(!rst)) |-> (b_out == $past(a_res)));
    assert_live_ba_R3: assert property (@(posedge clk) disable iff (rst)
        (!b_to_a_held && $past(!rst)) |-> (a_out == $past(b_res)));

    assert_held_ab_R4: assert property (@(posedge clk) disable iff (rst)
        (a_to_b_held && $past(a_to_b_held) && !$past(cap_a_fire) && $past(!rst))
        |-> $stable(b_out));
    assert_held_ba_R4: assert property (@(posedge clk) disable iff (rst)
        (b_to_a_held && $past(b_to_a_held) && !$past(cap_b_fire) && $past(!rst))
        |-> $stable(a_out));

    assert_pulse_a_R5: assert property (@(posedge clk) disable iff (rst)
        cap_a_fire |=> !cap_a_fire);
    assert_pulse_b_R5: assert property (@(posedge clk) disable iff (rst)
        cap_b_fire |=> !cap_b_fire);

    assert_load_a_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(cap_a_fire) && a_to_b_held) |-> (b_out == $past(a_res)));
    assert_load_b_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(cap_b_fire) && b_to_a_held) |-> (a_out == $past(b_res)));

    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (loop_live && $past(loop_live) && $past(a_out == b_out) && $past(!rst))
        |-> (a_out == b_out && $stable(a_out)));
endmodule

bind xcvr_top xcvr_checks #(.W(W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .a_in        (a_in),
    .a_out       (a_out),
    .a_oe        (a_oe),
    .b_in        (b_in),
    .b_out       (b_out),
    .b_oe        (b_oe),
    .a_to_b_held (a_to_b_held),
    .b_to_a_held (b_to_a_held),
    .cap_a_fire  (cap_a_fire),
    .cap_b_fire  (cap_b_fire)
);

// File: tb/tb_xcvr_top.sv
`timescale 1ns/1ps
module tb_xcvr_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;
    logic         a_drive_en_n = 1'b1;
    logic         b_drive_en = 1'b0;
    logic         a_to_b_held = 1'b0;
    logic         b_to_a_held = 1'b0;
    logic         cap_a_strobe = 1'b0;
    logic         cap_b_strobe = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    xcvr_top #(.W(W)) dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .a_drive_en_n(a_drive_en_n), .b_drive_en(b_drive_en),
        .a_to_b_held(a_to_b_held), .b_to_a_held(b_to_a_held),
        .cap_a_strobe(cap_a_strobe), .cap_b_strobe(cap_b_strobe)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe high for 3 clocks, then low; capture lands before the end
    task automatic pulse(input bit do_a, input bit do_b);
        @(negedge clk);
        if (do_a) cap_a_strobe = 1'b1;
        if (do_b) cap_b_strobe = 1'b1;
        cyc(3);
        cap_a_strobe = 1'b0;
        cap_b_strobe = 1'b0;
        cyc(5);
    endtask

    task automatic isolate();
        a_drive_en_n = 1'b1;
        b_drive_en   = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R11: held outputs read zero after reset
        a_to_b_held = 1'b1; b_to_a_held = 1'b1;
        #1;
        check("R11 reset b_out", b_out, 8'h00);
        check("R11 reset a_out", a_out, 8'h00);

        // R2: enable polarities
        for (int k = 0; k < 4; k++) begin
            b_drive_en   = k[0];
            a_drive_en_n = k[1];
            #1;
            check("R2 b_oe", {7'b0, b_oe}, {7'b0, k[0]});
            check("R2 a_oe", {7'b0, a_oe}, {7'b0, ~k[1]});
        end
        isolate();

        // R1/R3/R5 sweep of every data value with both ports isolated
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] va;
            logic [W-1:0] vb;
            va = v[W-1:0];
            vb = va ^ 8'h5A;
            @(negedge clk);
            a_in = va; b_in = vb;
            a_to_b_held = 1'b0; b_to_a_held = 1'b0;
            cyc(2);
            check("R1 R3 live b_out", b_out, va);
            check("R1 R3 live a_out", a_out, vb);
            pulse(1'b1, 1'b1);
            a_to_b_held = 1'b1; b_to_a_held = 1'b1;
            a_in = ~va; b_in = ~vb;
            cyc(2);
            check("R4 R5 held b_out", b_out, va);
            check("R4 R5 held a_out", a_out, vb);
        end

        // R5: a strobe held high loads once only
        @(negedge clk);
        a_in = 8'hC3;
        cap_a_strobe = 1'b1;
        cyc(6);
        check("R5 first load", b_out, 8'hC3);
        a_in = 8'h18;
        cyc(8);
        check("R5 no reload while high", b_out, 8'hC3);
        cap_a_strobe = 1'b0;
        cyc(5);
        check("R5 no load on fall", b_out, 8'hC3);

        // R6: enabled port A captures its own drive, not a_in
        b_in = 8'h3C;
        pulse(1'b0, 1'b1);
        a_drive_en_n = 1'b0;
        a_in = 8'hFF;
        pulse(1'b1, 1'b0);
        check("R6 a reg takes a_out", b_out, 8'h3C);
        isolate();

        // R7: load A into both registers through live B
        @(negedge clk);
        a_to_b_held = 1'b0; b_drive_en = 1'b1;
        a_in = 8'h96; b_in = 8'h11;
        cyc(2);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        a_to_b_held = 1'b1; b_to_a_held = 1'b1;
        cyc(1);
        check("R7 a reg", b_out, 8'h96);
        check("R7 b reg", a_out, 8'h96);

        // R8: bus hold with both live directions enabled
        @(negedge clk);
        a_to_b_held = 1'b0; b_to_a_held = 1'b0;
        a_drive_en_n = 1'b1; b_drive_en = 1'b1;
        a_in = 8'h4D;
        cyc(3);
        a_drive_en_n = 1'b0;
        cyc(2);
        a_in = 8'h00; b_in = 8'hFF;
        cyc(6);
        check("R8 hold a_out", a_out, 8'h4D);
        check("R8 hold b_out", b_out, 8'h4D);

        // R9: both stored values cross at once
        isolate();
        @(negedge clk);
        a_in = 8'h21; b_in = 8'h84;
        pulse(1'b1, 1'b1);
        a_to_b_held = 1'b1; b_to_a_held = 1'b1;
        a_drive_en_n = 1'b0; b_drive_en = 1'b1;
        cyc(2);
        check("R9 b_out", b_out, 8'h21);
        check("R9 a_out", a_out, 8'h84);

        // R10: coincident strobes exchange the registers
        pulse(1'b1, 1'b1);
        check("R10 swap b_out", b_out, 8'h84);
        check("R10 swap a_out", a_out, 8'h21);
        // R10: single strobe copies the other register
        pulse(1'b1, 1'b0);
        check("R10 copy b_out", b_out, 8'h21);
        check("R10 copy a_out", a_out, 8'h21);

        // R11: reset mid-run clears the registers
        @(negedge clk);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        #1;
        check("R11 mid reset b_out", b_out, 8'h00);
        check("R11 mid reset a_out", a_out, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule